// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory bus. It takes word-sized processor stores, each with a per-byte enable, and holds them so the processor can move on without waiting for memory. A store is taken whenever a free slot exists. Each slot holds one block, which is an aligned group of four 32-bit words. The slot stores the block address, the block data and a byte-valid mask.

Each new store's block address is compared against every pending slot that is still open for merging. On a match, the enabled bytes are folded into that slot and no slot is consumed. Otherwise the store takes the next free slot in arrival order. Slots leave the drain port oldest first, each as a single block-wide transfer with its byte mask, through a valid/ready handshake. The slot being offered on the drain port is closed: nothing merges into it, and a store to its block opens a fresh slot.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset, `wrReady` is 1 and `drnValid` is 0.
- R2: A store is accepted exactly in a cycle where `wrValid` and `wrReady` are both 1. `wrReady` is 1 whenever fewer than four slots are occupied. A store presented while `wrReady` is 0 leaves the buffer contents unchanged.
- R3: A store that matches no open slot occupies a new slot. When all four slots are occupied, `wrReady` is 0.
- R4: A store is merged when its block address (`wrAddr[31:4]`) equals that of an occupied slot that is not being offered on the drain port. A merged store consumes no slot.
- R5: Bits `wrAddr[3:2]` select the word w within the block, and `wrAddr[1:0]` are ignored. For each set bit b of `wrBe`, byte b of `wrData` lands in `drnData[32*w+8*b +: 8]` and sets `drnMask[4*w+b]`.
- R6: When several stores write the same byte of a slot, the slot holds the byte from the most recent store.
- R7: `drnValid` is 1 whenever any slot is occupied. Slots are offered in the order they were opened. A slot is removed on a cycle where `drnValid` and `drnReady` are both 1.
- R8: While `drnValid` is 1 and `drnReady` is 0, the drain outputs hold steady. A store to the offered slot's block opens a new slot rather than changing the offered one.
- R9: Bytes of an offered slot whose mask bit is 0 read as zero on `drnData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Processor store present |
| wrReady | output | 1 | Buffer can take a store |
| wrAddr | input | 32 | Byte address of the store |
| wrData | input | 32 | Store data word |
| wrBe | input | 4 | Byte enables for `wrData` |
| drnValid | output | 1 | A block is offered to memory |
| drnReady | input | 1 | Memory takes the offered block |
| drnAddr | output | 28 | Block address of the offered block |
| drnData | output | 128 | Block data, word 0 in the low bits |
| drnMask | output | 16 | Byte-valid mask for `drnData` |

## Verification
Directed stores with the drain stalled cover four cases. Stores to sequential words of one block show whether they merge or allocate. Overlapping byte enables on one word expose an oldest-wins error. A store to the block already on the drain port shows whether the offered slot is locked. Four distinct blocks show the full stall and that a refused store has no effect. Random traffic over only four block addresses then mixes merges, allocations, back-pressure and drain in the same cycles. A reference queue in the bench models the buffer, so each check can tell whether a slot was merged, allocated or removed in the wrong order.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef struct packed {
    logic allocEn;
    logic mergeEn;
    logic popEn;
  } wbm_strobe_t;
endpackage

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrValid,
  input  logic                   drnReady,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  output logic                   wrReady,
  output logic                   drnValid,
  output wbm_strobe_t            strb,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       rdIdx,
  output logic [NUM_ENTRIES-1:0] validVec
);
  logic [IDX_W-1:0] head, tail, hitIdx;
  logic             hit, accept;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrReady  = !validVec[tail];
  assign drnValid = validVec[head];
  assign accept   = wrValid && wrReady;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!hit && validVec[i] && matchVec[i] && (IDX_W'(i) != head)) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign strb.allocEn = accept && !hit;
  assign strb.mergeEn = accept && hit;
  assign strb.popEn   = drnValid && drnReady;
  assign wrIdx        = hit ? hitIdx : tail;
  assign rdIdx        = head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      validVec <= '0;
    end else begin
      if (strb.allocEn) begin
        tail           <= nextPtr(tail);
        validVec[tail] <= 1'b1;
      end
      if (strb.popEn) begin
        head           <= nextPtr(head);
        validVec[head] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wbm_data.sv
module wbm_data
  import wbm_pkg::*;
#(
  parameter int NUM_ENTRIES     = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int DATA_W          = 32,
  parameter int ADDR_W          = 32,
  parameter int IDX_W           = 2,
  localparam int BYTES  = DATA_W / 8,
  localparam int BSEL_W = $clog2(BYTES),
  localparam int WSEL_W = $clog2(WORDS_PER_BLOCK),
  localparam int OFF_W  = BSEL_W + WSEL_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = WORDS_PER_BLOCK * DATA_W,
  localparam int MASK_W = WORDS_PER_BLOCK * BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  wbm_strobe_t            strb,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-1:0]       rdIdx,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [BYTES-1:0]       wrBe,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic [BLK_W-1:0]       rdAddr,
  output logic [LINE_W-1:0]      rdData,
  output logic [MASK_W-1:0]      rdMask
);
  logic [BLK_W-1:0]  blkAddr  [NUM_ENTRIES];
  logic [LINE_W-1:0] lineData [NUM_ENTRIES];
  logic [MASK_W-1:0] lineMask [NUM_ENTRIES];

  logic [BLK_W-1:0]  wrBlk;
  logic [WSEL_W-1:0] wordSel;
  logic [LINE_W-1:0] newLine;
  logic [MASK_W-1:0] newMask;

  assign wrBlk   = wrAddr[ADDR_W-1:OFF_W];
  assign wordSel = wrAddr[OFF_W-1:BSEL_W];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = (blkAddr[g] == wrBlk);
  end

  // A fresh slot starts from zero data and an empty mask; a merge starts from the slot.
  always_comb begin
    newLine = strb.allocEn ? '0 : lineData[wrIdx];
    newMask = strb.allocEn ? '0 : lineMask[wrIdx];
    for (int w = 0; w < WORDS_PER_BLOCK; w++) begin
      for (int b = 0; b < BYTES; b++) begin
        if ((WSEL_W'(w) == wordSel) && wrBe[b]) begin
          newLine[w*DATA_W + b*8 +: 8] = wrData[b*8 +: 8];
          newMask[w*BYTES + b]         = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        blkAddr[i]  <= '0;
        lineData[i] <= '0;
        lineMask[i] <= '0;
      end
    end else if (strb.allocEn || strb.mergeEn) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (wrIdx == IDX_W'(i)) begin
          if (strb.allocEn) blkAddr[i] <= wrBlk;
          lineData[i] <= newLine;
          lineMask[i] <= newMask;
        end
      end
    end
  end

  assign rdAddr = blkAddr[rdIdx];
  assign rdData = lineData[rdIdx];
  assign rdMask = lineMask[rdIdx];
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
  import wbm_pkg::*;
#(
  parameter int NUM_ENTRIES     = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int DATA_W          = 32,
  parameter int ADDR_W          = 32
) (
  input  logic                                                      clk,
  input  logic                                                      rst_n,
  input  logic                                                      wrValid,
  output logic                                                      wrReady,
  input  logic [ADDR_W-1:0]                                         wrAddr,
  input  logic [DATA_W-1:0]                                         wrData,
  input  logic [DATA_W/8-1:0]                                       wrBe,
  output logic                                                      drnValid,
  input  logic                                                      drnReady,
  output logic [ADDR_W-$clog2(WORDS_PER_BLOCK*DATA_W/8)-1:0]        drnAddr,
  output logic [WORDS_PER_BLOCK*DATA_W-1:0]                         drnData,
  output logic [WORDS_PER_BLOCK*DATA_W/8-1:0]                       drnMask
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  wbm_strobe_t            strb;
  logic [IDX_W-1:0]       wrIdx, rdIdx;
  logic [NUM_ENTRIES-1:0] matchVec, validVec;

  wbm_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .drnReady(drnReady),
    .matchVec(matchVec), .wrReady(wrReady), .drnValid(drnValid),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .validVec(validVec)
  );

  wbm_data #(
    .NUM_ENTRIES(NUM_ENTRIES), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .matchVec(matchVec),
    .rdAddr(drnAddr), .rdData(drnData), .rdMask(drnMask)
  );
endmodule

// File: rtl/merge_write_buffer_chk.sv
module merge_write_buffer_chk #(
  parameter int NUM_ENTRIES = 4,
  parameter int BLK_W       = 28,
  parameter int LINE_W      = 128,
  parameter int MASK_W      = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrValid,
  input logic                   wrReady,
  input logic                   drnValid,
  input logic                   drnReady,
  input logic [BLK_W-1:0]       drnAddr,
  input logic [LINE_W-1:0]      drnData,
  input logic [MASK_W-1:0]      drnMask,
  input logic [NUM_ENTRIES-1:0] validVec
);
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (&validVec) |-> !wrReady); // R3
  AST_FREE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(&validVec) |-> wrReady); // R2
  AST_HELD_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (|validVec) |-> drnValid); // R7
  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (drnValid && drnReady && !(wrValid && wrReady)) |=>
      ($countones(validVec) + 1 == $past($countones(validVec)))); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wrValid && wrReady) && !(drnValid && drnReady)) |=> $stable(validVec)); // R2
  AST_ACCEPT_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrReady && !(drnValid && drnReady)) |=>
      ($countones(validVec) <= $past($countones(validVec)) + 1 &&
       $countones(validVec) >= $past($countones(validVec)))); // R4
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drnValid && !drnReady) |=>
      (drnValid && $stable(drnAddr) && $stable(drnData) && $stable(drnMask))); // R8
endmodule

bind merge_write_buffer merge_write_buffer_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .BLK_W(ADDR_W - $clog2(WORDS_PER_BLOCK * DATA_W / 8)),
  .LINE_W(WORDS_PER_BLOCK * DATA_W),
  .MASK_W(WORDS_PER_BLOCK * DATA_W / 8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
  .drnValid(drnValid), .drnReady(drnReady), .drnAddr(drnAddr),
  .drnData(drnData), .drnMask(drnMask), .validVec(validVec)
);

// File: tb/merge_write_buffer_tb.sv
`timescale 1ns/1ps
module merge_write_buffer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wrValid, wrReady, drnValid, drnReady;
  logic [31:0]  wrAddr, wrData;
  logic [3:0]   wrBe;
  logic [27:0]  drnAddr;
  logic [127:0] drnData;
  logic [15:0]  drnMask;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [27:0]  a;
    logic [127:0] d;
    logic [15:0]  m;
  } slot_t;
  slot_t q[$];

  always #10 clk = ~clk;

  merge_write_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .drnValid(drnValid),
    .drnReady(drnReady), .drnAddr(drnAddr), .drnData(drnData), .drnMask(drnMask)
  );

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    chk(tag, "wrReady", 128'(wrReady), 128'(q.size() < 4));
    chk(tag, "drnValid", 128'(drnValid), 128'(q.size() > 0));
    if (q.size() > 0) begin
      chk(tag, "drnAddr", 128'(drnAddr), 128'(q[0].a));
      chk(tag, "drnMask", 128'(drnMask), 128'(q[0].m));
      chk(tag, "drnData", drnData, q[0].d);
    end
  endtask

  // One cycle: check current outputs, drive inputs, advance the reference queue.
  task automatic step(input bit wv, input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit rdy, input string tag);
    int  pre;
    int  hitAt;
    checkOutputs(tag);
    wrValid = wv; wrAddr = a; wrData = d; wrBe = be; drnReady = rdy;
    pre = q.size();
    if (wv && pre < 4) begin
      hitAt = -1;
      for (int i = 1; i < pre; i++) if (q[i].a == a[31:4]) hitAt = i;
      if (hitAt < 0) begin
        slot_t s;
        s.a = a[31:4]; s.d = '0; s.m = '0;
        q.push_back(s);
        hitAt = q.size() - 1;
      end
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          q[hitAt].d[32*a[3:2] + 8*b +: 8] = d[8*b +: 8];
          q[hitAt].m[4*a[3:2] + b] = 1'b1;
        end
      end
    end
    if (pre > 0 && rdy) void'(q.pop_front());
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; wrValid = 0; wrAddr = '0; wrData = '0; wrBe = '0; drnReady = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "wrReady after reset", 128'(wrReady), 128'(1));
    chk("R1", "drnValid after reset", 128'(drnValid), 128'(0));

    // Drain stalled: build merges, a lock case and a full buffer.
    step(1, 32'h0000_0100, 32'hAAAA_0001, 4'hF, 0, "R3");
    step(1, 32'h0000_0204, 32'h1122_3344, 4'h3, 0, "R4");
    step(1, 32'h0000_0205, 32'h5566_7788, 4'h1, 0, "R6");
    step(1, 32'h0000_020F, 32'hDEAD_BEEF, 4'hC, 0, "R5");
    step(1, 32'h0000_0108, 32'h1234_5678, 4'hF, 0, "R8");
    step(1, 32'h0000_0300, 32'hCAFE_F00D, 4'hF, 0, "R4");
    step(1, 32'h0000_0400, 32'h0BAD_0BAD, 4'hF, 0, "R3");
    step(1, 32'h0000_0304, 32'h7777_7777, 4'hF, 0, "R2");
    step(0, 32'h0, 32'h0, 4'h0, 0, "R8");
    step(0, 32'h0, 32'h0, 4'h0, 1, "R7");
    step(0, 32'h0, 32'h0, 4'h0, 1, "R9");
    step(0, 32'h0, 32'h0, 4'h0, 1, "R7");
    step(0, 32'h0, 32'h0, 4'h0, 1, "R9");
    step(0, 32'h0, 32'h0, 4'h0, 0, "R7");

    // Random traffic over four blocks with drain back-pressure.
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 7,
           32'h100 + 32'(($urandom % 4) * 16) + 32'($urandom % 16),
           $urandom, 4'($urandom % 16), ($urandom % 10) < 3, "R4");
    end
    for (int n = 0; n < 6; n++) step(0, 32'h0, 32'h0, 4'h0, 1, "R7");
    checkOutputs("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule